// File: doc/BRIEF.md
# Cache line lock controller

This block holds the tag, valid and lock state of a small set-associative cache. A command port accepts one operation at a time. Three operations fetch and pin a line: one for loads, one for stores and one for instruction fetch. A fourth operation unpins a line, and a fifth is an ordinary access that allocates on a miss without pinning. Each command carries a byte address and a two-bit cache-target code. The block looks the address up, and when a pin or access misses it requests a line fill on a request/acknowledge port. It then updates the per-way lock bit and reports the outcome with a one-cycle completion pulse.

Lock state is kept for every index and way, so a single line can be pinned. Replacement victims for allocating misses are chosen per set. An empty way is taken first. Otherwise the choice rotates among the unpinned ways, and a pinned way is never chosen. When every way of a set is pinned, the fill is refused and a sticky overflow flag is raised. A flash-clear input unpins every line in a single cycle and leaves the lines resident.

The data array, the memory behind the fill port and effective-address generation sit outside the block.

Top module: `linelock_ctrl`

## Requirements
- R1: Pin and unpin commands (op 0..3) are carried out only when their target code equals the THIS_LEVEL parameter. The other valid code (0 or 1) completes with no state change, no fill and done_hit=0.
- R2: A pin or unpin command with target code 2 or 3, and any command with op 5, 6 or 7, is a no-op: no fill, no state change, done_hit=0, done_locked=0.
- R3: There is one lock bit per index and way. Pinning one line leaves every other line of the same set unpinned.
- R4: A pin command (op 0 load, 1 store, 2 instruction) that misses raises fill_req with fill_addr equal to the command address. It holds fill_req until fill_ack, then allocates the line with its lock bit set and reports done_locked=1 and done_hit=0.
- R5: A pin command that hits issues no fill and sets only the hit way's lock bit. It reports done_hit=1, done_way equal to the hit way and done_locked=1.
- R6: An unpin command (op 3) that hits clears the lock bit of the hit way and reports done_hit=1 and done_locked=0. One that misses changes nothing.
- R7: The allocation victim is the lowest-numbered invalid way if one exists. Otherwise it is the first unlocked way found rotating upward from the set's pointer. The pointer becomes victim+1 (mod WAYS) after every allocation and starts at 0. A locked way is never chosen.
- R8: If a fill is needed and every way of the set is locked, no fill is requested, nothing is allocated and lock_ovf is set. lock_ovf stays set until ovf_clr is pulsed.
- R9: cmd_ready is high only while idle and stays low from acceptance through the fill to completion. done is a one-cycle pulse for every command, no-ops included.
- R10: A flash_clr pulse clears all lock bits in one cycle and leaves every line valid.
- R11: An access command (op 4, target ignored) that hits reports the line's lock bit in done_locked. One that misses allocates the line with its lock bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_op | input | 3 | 0 pin-load, 1 pin-store, 2 pin-instruction, 3 unpin, 4 access, 5..7 no-op |
| cmd_tgt | input | 2 | Cache-target code |
| cmd_addr | input | ADDR_W | Byte address |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | ADDR_W | Byte address whose line is to be filled |
| fill_ack | input | 1 | Fill complete |
| done | output | 1 | Command completed (one cycle) |
| done_hit | output | 1 | Line was resident at lookup |
| done_way | output | WAY_W | Way hit or allocated |
| done_locked | output | 1 | Lock bit of that line after the command |
| flash_clr | input | 1 | Clear every lock bit |
| lock_ovf | output | 1 | Sticky: a fill was refused because the set was fully locked |
| ovf_clr | input | 1 | Clear lock_ovf |

## Verification
The hardest state to reach from the ports is a set whose every way is pinned, followed by an unpin of one way, with the rotating pointer sitting on a locked way. Only that combination shows both the refusal and the skip over locked ways. The stimulus gets there with a directed run that fills and pins a single set to capacity, provokes a refused access, unpins one way and then allocates again. The random phase draws addresses from six tags per set over four ways, so sets fill up and lock out repeatedly, with interleaved flash clears and unpins.

// File: rtl/linelock_pkg.sv
package linelock_pkg;
  localparam logic [2:0] OP_PIN_LD  = 3'd0;
  localparam logic [2:0] OP_PIN_ST  = 3'd1;
  localparam logic [2:0] OP_PIN_IF  = 3'd2;
  localparam logic [2:0] OP_UNPIN   = 3'd3;
  localparam logic [2:0] OP_ACCESS  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2,
    ST_DONE = 2'd3
  } ll_state_e;
endpackage

// File: rtl/linelock_store.sv
module linelock_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  valid_vec,
  output logic [WAYS-1:0]  lock_vec,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic             wr_lock,
  input  logic             lk_set,
  input  logic             lk_clr,
  input  logic [WAY_W-1:0] lk_way,
  input  logic             flash_clr
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [WAYS-1:0]  lock_q [SETS];
  logic [WAYS-1:0]  lock_d [SETS];

  // read side of the addressed set
  always_comb begin
    valid_vec = valid_q[idx];
    lock_vec  = lock_q[idx];
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == rd_tag);
    end
  end

  // next state; flash clear has the last word on lock bits
  always_comb begin
    valid_d = valid_q;
    lock_d  = lock_q;
    if (wr_en) begin
      valid_d[idx][wr_way] = 1'b1;
      lock_d[idx][wr_way]  = wr_lock;
    end
    if (lk_set) lock_d[idx][lk_way] = 1'b1;
    if (lk_clr) lock_d[idx][lk_way] = 1'b0;
    if (flash_clr) begin
      for (int s = 0; s < SETS; s++) lock_d[s] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        lock_q[s]  <= '0;
      end
    end else begin
      valid_q <= valid_d;
      lock_q  <= lock_d;
    end
  end

  // tag array: no reset, written only on allocation
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[idx][wr_way] <= rd_tag;
  end

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_chk
      // R3: a lock bit is only ever held by a resident line
      a_r3_lock_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q[s] & ~valid_q[s]) == '0);
      // R10: flash clear leaves no lock bit behind and keeps lines resident
      a_r10_flash_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flash_clr |=> (lock_q[s] == '0) && ((valid_q[s] & $past(valid_q[s])) == $past(valid_q[s])));
    end
  endgenerate
endmodule

// File: rtl/linelock_victim.sv
module linelock_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAYS-1:0]  lock_vec,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic             vic_ok,
  output logic [WAY_W-1:0] vic_way
);
  logic [WAYS-1:0] free_vec;
  logic            inv_found;
  logic [WAY_W-1:0] inv_way;
  logic            rot_found;
  logic [WAY_W-1:0] rot_way;

  assign free_vec = ~lock_vec;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!inv_found && !valid_vec[w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
  end

  always_comb begin
    rot_found = 1'b0;
    rot_way   = '0;
    for (int k = 0; k < WAYS; k++) begin
      int p;
      p = (int'(rr_ptr) + k) % WAYS;
      if (!rot_found && free_vec[p]) begin
        rot_found = 1'b1;
        rot_way   = WAY_W'(p);
      end
    end
  end

  assign vic_ok  = inv_found || rot_found;
  assign vic_way = inv_found ? inv_way : rot_way;

  // R7: a pinned way is never offered for replacement
  a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    vic_ok |-> !lock_vec[vic_way]);
  // R8: refusal only when every way is pinned
  a_r8_refuse_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_ok |-> (lock_vec == {WAYS{1'b1}}));
endmodule

// File: rtl/linelock_fsm.sv
module linelock_fsm
  import linelock_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 4,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter logic [1:0] THIS_LEVEL = 2'd0,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_tgt,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_ack,
  output logic              done,
  output logic              done_hit,
  output logic [WAY_W-1:0]  done_way,
  output logic              done_locked,
  output logic              lock_ovf,
  input  logic              ovf_clr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag,
  input  logic [WAYS-1:0]   hit_vec,
  input  logic [WAYS-1:0]   lock_vec,
  output logic [WAY_W-1:0]  rr_sel,
  input  logic              vic_ok,
  input  logic [WAY_W-1:0]  vic_way,
  output logic              wr_en,
  output logic [WAY_W-1:0]  wr_way,
  output logic              wr_lock,
  output logic              lk_set,
  output logic              lk_clr,
  output logic [WAY_W-1:0]  lk_way
);
  ll_state_e         state_q, state_d;
  logic [2:0]        op_q, op_d;
  logic [1:0]        tgt_q, tgt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              hit_q, hit_d;
  logic [WAY_W-1:0]  way_q, way_d;
  logic              lkd_q, lkd_d;
  logic              ovf_q, ovf_d;
  logic [WAY_W-1:0]  rr_q [SETS];
  logic [WAY_W-1:0]  rr_d [SETS];

  logic             is_pin, is_unpin, is_acc, live, any_hit;
  logic [WAY_W-1:0] hit_way;

  assign idx       = addr_q[OFF_W +: IDX_W];
  assign tag       = addr_q[ADDR_W-1 -: TAG_W];
  assign rr_sel    = rr_q[idx];
  assign cmd_ready = (state_q == ST_IDLE);
  assign fill_req  = (state_q == ST_FILL);
  assign fill_addr = addr_q;
  assign done      = (state_q == ST_DONE);
  assign done_hit  = hit_q;
  assign done_way  = way_q;
  assign done_locked = lkd_q;
  assign lock_ovf  = ovf_q;

  assign is_pin   = (op_q == OP_PIN_LD) || (op_q == OP_PIN_ST) || (op_q == OP_PIN_IF);
  assign is_unpin = (op_q == OP_UNPIN);
  assign is_acc   = (op_q == OP_ACCESS);
  assign live     = is_acc || ((is_pin || is_unpin) && (tgt_q == THIS_LEVEL));
  assign any_hit  = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    tgt_d   = tgt_q;
    addr_d  = addr_q;
    hit_d   = hit_q;
    way_d   = way_q;
    lkd_d   = lkd_q;
    ovf_d   = ovf_q && !ovf_clr;
    rr_d    = rr_q;
    wr_en   = 1'b0;
    wr_way  = way_q;
    wr_lock = is_pin;
    lk_set  = 1'b0;
    lk_clr  = 1'b0;
    lk_way  = hit_way;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          op_d    = cmd_op;
          tgt_d   = cmd_tgt;
          addr_d  = cmd_addr;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        hit_d   = 1'b0;
        way_d   = '0;
        lkd_d   = 1'b0;
        state_d = ST_DONE;
        if (live) begin
          if (any_hit) begin
            hit_d = 1'b1;
            way_d = hit_way;
            if (is_pin) begin
              lk_set = 1'b1;
              lkd_d  = 1'b1;
            end else if (is_unpin) begin
              lk_clr = 1'b1;
            end else begin
              lkd_d  = lock_vec[hit_way];
            end
          end else if (!is_unpin) begin
            if (vic_ok) begin
              way_d   = vic_way;
              state_d = ST_FILL;
            end else begin
              ovf_d   = 1'b1;
            end
          end
        end
      end
      ST_FILL: begin
        if (fill_ack) begin
          wr_en   = 1'b1;
          lkd_d   = is_pin;
          rr_d[idx] = (way_q == WAY_W'(WAYS - 1)) ? '0 : way_q + 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      tgt_q   <= '0;
      addr_q  <= '0;
      hit_q   <= 1'b0;
      way_q   <= '0;
      lkd_q   <= 1'b0;
      ovf_q   <= 1'b0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      tgt_q   <= tgt_d;
      addr_q  <= addr_d;
      hit_q   <= hit_d;
      way_q   <= way_d;
      lkd_q   <= lkd_d;
      ovf_q   <= ovf_d;
      rr_q    <= rr_d;
    end
  end

  // R9: the port stays closed while a fill is outstanding
  a_r9_busy_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !cmd_ready);
  // R9: request and address hold until acknowledged
  a_r9_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: unsupported target code never leads to a fill
  a_r2_noop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOK && !is_acc && tgt_q[1]) |=> (done && !fill_req && !hit_q));
  // R5: a pin that hits goes straight to completion
  a_r5_hit_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOK && is_pin && live && any_hit) |=> (done && lkd_q));
  // R8: overflow flag is sticky until cleared
  a_r8_no_overflow_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_ovf && !ovf_clr) |=> lock_ovf);
endmodule

// File: rtl/linelock_ctrl.sv
module linelock_ctrl #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 4,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter logic [1:0] THIS_LEVEL = 2'd0,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_tgt,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_ack,
  output logic              done,
  output logic              done_hit,
  output logic [WAY_W-1:0]  done_way,
  output logic              done_locked,
  input  logic              flash_clr,
  output logic              lock_ovf,
  input  logic              ovf_clr
);
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [WAYS-1:0]  hit_vec, valid_vec, lock_vec;
  logic [WAY_W-1:0] rr_sel, vic_way, wr_way, lk_way;
  logic             vic_ok, wr_en, wr_lock, lk_set, lk_clr;

  linelock_fsm #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS), .THIS_LEVEL(THIS_LEVEL)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_tgt(cmd_tgt), .cmd_addr(cmd_addr),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_ack(fill_ack),
    .done(done), .done_hit(done_hit), .done_way(done_way), .done_locked(done_locked),
    .lock_ovf(lock_ovf), .ovf_clr(ovf_clr),
    .idx(idx), .tag(tag), .hit_vec(hit_vec), .lock_vec(lock_vec),
    .rr_sel(rr_sel), .vic_ok(vic_ok), .vic_way(vic_way),
    .wr_en(wr_en), .wr_way(wr_way), .wr_lock(wr_lock),
    .lk_set(lk_set), .lk_clr(lk_clr), .lk_way(lk_way)
  );

  linelock_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(idx), .rd_tag(tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .lock_vec(lock_vec),
    .wr_en(wr_en), .wr_way(wr_way), .wr_lock(wr_lock),
    .lk_set(lk_set), .lk_clr(lk_clr), .lk_way(lk_way), .flash_clr(flash_clr)
  );

  linelock_victim #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .lock_vec(lock_vec),
    .rr_ptr(rr_sel), .vic_ok(vic_ok), .vic_way(vic_way)
  );
endmodule

// File: tb/linelock_ctrl_bench.sv
module linelock_ctrl_bench;
  localparam int AW = 12;
  localparam int NS = 4;
  localparam int NW = 4;
  localparam logic [1:0] LVL = 2'd0;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready, fill_req, fill_ack, done, done_hit, done_locked;
  logic flash_clr, lock_ovf, ovf_clr;
  logic [2:0] cmd_op;
  logic [1:0] cmd_tgt;
  logic [AW-1:0] cmd_addr, fill_addr;
  logic [1:0] done_way;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // bench model of the cache state
  int  m_tag [NS][NW];
  bit  m_val [NS][NW];
  bit  m_lock [NS][NW];
  int  m_rr [NS];
  bit  m_ovf;

  always #2 clk = ~clk;

  linelock_ctrl #(.ADDR_W(AW), .OFF_W(4), .SETS(NS), .WAYS(NW), .THIS_LEVEL(LVL)) u_linelock_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_tgt(cmd_tgt), .cmd_addr(cmd_addr),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_ack(fill_ack),
    .done(done), .done_hit(done_hit), .done_way(done_way), .done_locked(done_locked),
    .flash_clr(flash_clr), .lock_ovf(lock_ovf), .ovf_clr(ovf_clr)
  );

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int pick(input int s);
    for (int w = 0; w < NW; w++) if (!m_val[s][w]) return w;
    for (int k = 0; k < NW; k++) begin
      int p = (m_rr[s] + k) % NW;
      if (!m_lock[s][p]) return p;
    end
    return -1;
  endfunction

  function automatic logic [AW-1:0] mk(input int t, input int s, input int off);
    return {t[5:0], s[1:0], off[3:0]};
  endfunction

  // one command through model and design
  task automatic run_cmd(input logic [2:0] op, input logic [1:0] tgt, input logic [AW-1:0] a);
    int s, t, hw, v, ew, waitn;
    bit ef, eh, el, saw_fill;
    string rq;
    s = int'(a[5:4]); t = int'(a[11:6]);
    ef = 0; eh = 0; el = 0; ew = 0; hw = -1;
    for (int w = 0; w < NW; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
    if (op > 3'd4) rq = "R2";
    else if (op < 3'd4 && tgt > 2'd1) rq = "R2";
    else if (op < 3'd4 && tgt != LVL) rq = "R1";
    else if (op == 3'd3) begin
      rq = "R6";
      if (hw >= 0) begin eh = 1; ew = hw; m_lock[s][hw] = 0; end
    end else if (hw >= 0) begin
      eh = 1; ew = hw;
      if (op == 3'd4) begin el = m_lock[s][hw]; rq = "R11"; end
      else begin m_lock[s][hw] = 1; el = 1; rq = "R5"; end
    end else begin
      v = pick(s);
      if (v < 0) begin m_ovf = 1; rq = "R8"; end
      else begin
        ef = 1; ew = v; m_val[s][v] = 1; m_tag[s][v] = t;
        m_lock[s][v] = (op != 3'd4); el = m_lock[s][v];
        m_rr[s] = (v + 1) % NW;
        rq = (op == 3'd4) ? "R11" : "R4";
      end
    end
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_tgt = tgt; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 1'b0, "R9", "ready after accept", cmd_ready, 0);
    saw_fill = 0;
    waitn = $urandom % 4;
    for (int i = 0; i < 60; i++) begin
      if (i > 0) @(negedge clk);
      fill_ack = 0;
      if (done) break;
      if (fill_req) begin
        if (!saw_fill) begin
          saw_fill = 1;
          chk(fill_addr == a, "R4", "fill address", fill_addr, a);
        end
        chk(cmd_ready == 1'b0, "R9", "ready during fill", cmd_ready, 0);
        if (waitn == 0) fill_ack = 1; else waitn--;
      end
      if (i == 59) chk(0, "R9", "no completion", 0, 1);
    end
    chk(saw_fill == ef, rq, "fill issued", saw_fill, ef);
    chk(done_hit == eh, rq, "done_hit", done_hit, eh);
    chk(done_locked == el, rq, "done_locked", done_locked, el);
    if (eh || ef) chk(int'(done_way) == ew, ef ? "R7" : rq, "done_way", done_way, ew);
    chk(lock_ovf == m_ovf, "R8", "lock_ovf", lock_ovf, m_ovf);
    @(negedge clk);
    chk(done == 1'b0 && cmd_ready == 1'b1, "R9", "done pulse width", done, 0);
  endtask

  task automatic pulse_flash();
    @(negedge clk); flash_clr = 1;
    @(negedge clk); flash_clr = 0;
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) m_lock[s][w] = 0;
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    m_ovf = 0;
    chk(lock_ovf == 1'b0, "R8", "ovf cleared", lock_ovf, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_tgt = 0; cmd_addr = 0;
    fill_ack = 0; flash_clr = 0; ovf_clr = 0;
    for (int s = 0; s < NS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < NW; w++) begin m_val[s][w] = 0; m_lock[s][w] = 0; m_tag[s][w] = 0; end
    end
    m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1 && fill_req == 0 && done == 0 && lock_ovf == 0, "R9", "reset state", cmd_ready, 1);

    // directed: fill and pin one set to capacity
    run_cmd(3'd0, LVL, mk(1, 1, 3));   // R4 miss, way 0
    run_cmd(3'd0, LVL, mk(1, 1, 9));   // R5 hit
    run_cmd(3'd4, 2'd1, mk(2, 1, 0));  // R11 access miss, unlocked, R3
    run_cmd(3'd1, LVL, mk(2, 1, 0));   // R5 store pin hit
    run_cmd(3'd2, LVL, mk(3, 1, 0));   // R4 instruction pin
    run_cmd(3'd0, LVL, mk(4, 1, 0));   // set full and pinned
    run_cmd(3'd4, LVL, mk(5, 1, 0));   // R8 refused
    run_cmd(3'd0, 2'd1, mk(6, 1, 0));  // R1 other level
    run_cmd(3'd0, 2'd2, mk(6, 1, 0));  // R2 bad target
    run_cmd(3'd3, 2'd3, mk(1, 1, 0));  // R2 bad target unpin
    run_cmd(3'd6, LVL, mk(6, 1, 0));   // R2 reserved op
    run_cmd(3'd3, LVL, mk(2, 1, 0));   // R6 unpin hit
    run_cmd(3'd4, LVL, mk(5, 1, 0));   // R7 only unlocked way
    run_cmd(3'd3, LVL, mk(9, 1, 0));   // R6 unpin miss
    run_cmd(3'd4, LVL, mk(1, 1, 0));   // still pinned
    pulse_ovf_clr();
    pulse_flash();                     // R10
    run_cmd(3'd4, LVL, mk(1, 1, 0));   // R10 resident, unpinned
    run_cmd(3'd4, LVL, mk(3, 1, 0));

    // random phase
    for (int n = 0; n < 400; n++) begin
      int r, t, s;
      logic [2:0] op;
      logic [1:0] tg;
      r = $urandom % 16;
      if (r < 4) op = 3'd0; else if (r < 6) op = 3'd1; else if (r < 8) op = 3'd2;
      else if (r < 11) op = 3'd3; else if (r < 15) op = 3'd4; else op = 3'(5 + $urandom % 3);
      r = $urandom % 20;
      tg = (r < 16) ? LVL : (r < 18) ? 2'd1 : 2'(2 + $urandom % 2);
      t = $urandom % 6; s = $urandom % NS;
      run_cmd(op, tg, mk(t, s, $urandom % 16));
      if ($urandom % 32 == 0) pulse_flash();
      if ($urandom % 20 == 0) pulse_ovf_clr();
    end
    summary_and_end();
  end
endmodule